// File: doc/BRIEF.md
# Queued-Sample Pulse-Width Modulator

This block produces one pulse-width modulated output from a small register file on a simple write/read bus. Software writes duty words into a short queue. The generator takes one word per output period, or holds a word for a programmed number of periods, and keeps the last word when the queue runs dry. A period lasts the period register value plus two counter ticks. The output is high from the start of each period until the counter reaches the duty word. After that it stays low until the period wraps.

The counter clock comes from one of three enable strobes, or from none. The chosen strobe then passes through a divider whose ratio can be set from 1 to 4096. Each event flag in the status word stays set until software writes a 1 to it. A self-clearing software reset flushes the queue and returns every register to its reset value.

Top module: `pwm_fifo_gen`

## Requirements
- R1: After reset, the control word (offset 0x00) reads 0, the status word (offset 0x04) reads 0x08, and the output is low.
- R2: With counter ticks on every cycle, one output period lasts (period register at offset 0x10) + 2 ticks. A period value of 0xFFFF gives the same period as 0xFFFE, which is 65536 ticks.
- R3: When control bits [19:18] are 0 (normal), the output is high for the first D ticks of each period, where D is the current duty word.
- R4: Control bits [19:18] = 1 inverts the output. Values 2 and 3 hold the output low.
- R5: While control bit 0 (enable) is 0, the output is low in every mode. The sample offset 0x0C reads the current duty word while enabled and reads 0 while disabled.
- R6: Control bits [15:4] hold the divide ratio minus one. A value of N stretches every tick to N+1 strobes.
- R7: Control bits [17:16] pick the tick strobe: 0 none (the counter holds), 1 bus strobe, 2 fast strobe, 3 slow strobe.
- R8: A write to offset 0x0C queues a duty word. Status bits [2:0] give the queue level (0 to 4), and status bit 3 is set while the queue is empty.
- R9: A write to a full queue is dropped and sets status bit 6.
- R10: On enable, the first queued word becomes the duty. Each word is used for 1, 2, 4 or 8 periods, as control bits [2:1] = 0, 1, 2, 3 select. An empty queue keeps the last word.
- R11: Status bit 4 is set at every period wrap. Status bit 5 is set on each tick where the counter equals the duty. Writing 1 to either bit clears it.
- R12: Writing control bit 3 starts a software reset. Control bit 3 reads 1 for RST_CYCLES cycles and then reads 0. The reset empties the queue and clears the control, period and flag state. Bus writes are ignored while it runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| src_bus_tick | input | 1 | Bus-clock enable strobe |
| src_fast_tick | input | 1 | High-speed clock enable strobe |
| src_slow_tick | input | 1 | Slow (32 kHz class) clock enable strobe |
| pwm_out | output | 1 | Modulated output |

## Verification
The bound checker checks these points on every cycle:
- the output is held low while disabled or in an off mode;
- the queue level stays within its depth;
- the counter stays frozen with no strobe selected;
- a write to a full queue always raises the drop flag;
- a software reset leaves the queue empty and the generator disabled.

Only the bench scenarios can show the following, because each needs whole periods to be measured:
- the exact high and period lengths;
- the effect of the divider and of each strobe;
- the order in which queued words are used, with their repeat counts;
- the 0xFFFF period limit;
- the clearing of flags on a write of 1.

// File: rtl/pwm_fifo_pkg.sv
package pwm_fifo_pkg;

   // register byte offsets
   localparam int OFS_CTRL = 'h00;
   localparam int OFS_STAT = 'h04;
   localparam int OFS_SMP  = 'h0C;
   localparam int OFS_PRD  = 'h10;

   // control bit positions
   localparam int CB_EN   = 0;
   localparam int CB_RPT  = 1;
   localparam int CB_SWR  = 3;
   localparam int CB_PRE  = 4;
   localparam int CB_SRC  = 16;
   localparam int CB_MODE = 18;

   // status bit positions (write-one-to-clear flags)
   localparam int SB_ROLL = 4;
   localparam int SB_CMP  = 5;
   localparam int SB_OVF  = 6;

   typedef enum logic [1:0] {
      OM_NORM = 2'd0,
      OM_INV  = 2'd1,
      OM_OFF  = 2'd2,
      OM_OFF2 = 2'd3
   } out_mode_e;

   typedef enum logic [1:0] {
      CS_NONE = 2'd0,
      CS_BUS  = 2'd1,
      CS_FAST = 2'd2,
      CS_SLOW = 2'd3
   } clk_src_e;

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
   parameter int PRE_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             src_tick,
   input  logic [PRE_W-1:0] ratio_m1,
   output logic             cnt_tick
);

   logic [PRE_W-1:0] div_q;
   logic             wrap;

   // >= keeps the divider sane when the ratio shrinks mid-count
   assign wrap     = (div_q >= ratio_m1);
   assign cnt_tick = src_tick && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         div_q <= '0;
      else if (clr)
         div_q <= '0;
      else if (src_tick)
         div_q <= wrap ? '0 : div_q + PRE_W'(1);
   end

endmodule

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [W-1:0]     wdata,
   input  logic             pop,
   output logic [W-1:0]     rdata,
   output logic [LVL_W-1:0] level,
   output logic             full,
   output logic             empty
);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wp, rp;
   logic             push_ok, pop_ok;

   assign full    = (level == LVL_W'(DEPTH));
   assign empty   = (level == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign rdata   = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else if (clr) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (push_ok) wp <= wp + PTR_W'(1);
         if (pop_ok)  rp <= rp + PTR_W'(1);
         level <= level + LVL_W'(push_ok) - LVL_W'(pop_ok);
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok && !clr)
         mem[wp] <= wdata;
   end

endmodule

// File: rtl/pwm_period_core.sv
module pwm_period_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] last,
   input  logic [CNT_W-1:0] duty,
   output logic [CNT_W-1:0] cnt,
   output logic             rollover,
   output logic             cmp_hit,
   output logic             raw
);

   logic at_end;

   assign at_end   = (cnt >= last);
   assign rollover = run && tick && at_end;
   assign cmp_hit  = run && tick && (cnt == duty);
   assign raw      = run && (cnt < duty);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run)
         cnt <= '0;
      else if (tick)
         cnt <= at_end ? '0 : cnt + CNT_W'(1);
   end

endmodule

// File: rtl/pwm_fifo_gen.sv
module pwm_fifo_gen
   import pwm_fifo_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int FIFO_DEPTH = 4,
   parameter int PRE_W      = 12,
   parameter int RST_CYCLES = 4,
   parameter int ADDR_W     = 5,
   parameter bit OUT_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              src_bus_tick,
   input  logic              src_fast_tick,
   input  logic              src_slow_tick,
   output logic              pwm_out
);

   localparam int LVL_W = $clog2(FIFO_DEPTH + 1);
   localparam int RST_W = $clog2(RST_CYCLES) + 1;

   // elaboration checks
   if (FIFO_DEPTH < 2 || FIFO_DEPTH > 7 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0)
      begin : g_bad_depth
         $error("FIFO_DEPTH must be 2 or 4");
      end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W must lie in 2..32");
   end
   if (PRE_W < 1 || PRE_W > 12) begin : g_bad_pre
      $error("PRE_W must lie in 1..12");
   end
   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("RST_CYCLES must be positive");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must reach offset 0x10");
   end

   // control state
   logic             ctl_en;
   logic [1:0]       ctl_rpt;
   logic [PRE_W-1:0] ctl_pre;
   clk_src_e         ctl_src;
   out_mode_e        ctl_mode;
   logic [CNT_W-1:0] prd_q, prd_last, cur_duty, cnt;
   logic             busy;
   logic [RST_W-1:0] rst_cnt;
   logic             en_q, run, start;
   logic [2:0]       rep_cnt, rep_len_m1;
   logic             flg_roll, flg_cmp, flg_ovf;
   logic             src_tick, cnt_tick, rollover, cmp_hit, raw, shaped;
   logic             fifo_full, fifo_empty, pop, rep_done;
   logic [CNT_W-1:0] fifo_rdata;
   logic [LVL_W-1:0] fifo_level;
   logic             acc, wr_ctrl, wr_stat, wr_smp, wr_prd, swr_req, clr;
   logic             unused_bits;

   assign unused_bits = ^reg_wdata;

   assign acc     = reg_we && !busy;
   assign wr_ctrl = acc && (reg_addr == ADDR_W'(OFS_CTRL));
   assign wr_stat = acc && (reg_addr == ADDR_W'(OFS_STAT));
   assign wr_smp  = acc && (reg_addr == ADDR_W'(OFS_SMP));
   assign wr_prd  = acc && (reg_addr == ADDR_W'(OFS_PRD));
   assign swr_req = wr_ctrl && reg_wdata[CB_SWR];
   assign clr     = busy || swr_req;

   // control and period registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || clr) begin
         ctl_en   <= 1'b0;
         ctl_rpt  <= '0;
         ctl_pre  <= '0;
         ctl_src  <= CS_NONE;
         ctl_mode <= OM_NORM;
      end else if (wr_ctrl) begin
         ctl_en   <= reg_wdata[CB_EN];
         ctl_rpt  <= reg_wdata[CB_RPT +: 2];
         ctl_pre  <= reg_wdata[CB_PRE +: PRE_W];
         ctl_src  <= clk_src_e'(reg_wdata[CB_SRC +: 2]);
         ctl_mode <= out_mode_e'(reg_wdata[CB_MODE +: 2]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || clr)  prd_q <= '0;
      else if (wr_prd)    prd_q <= reg_wdata[CNT_W-1:0];
   end

   // all-ones period is clamped to all-ones minus one
   assign prd_last = ((prd_q == '1) ? prd_q - CNT_W'(1) : prd_q) + CNT_W'(1);

   // self-clearing software reset sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         rst_cnt <= '0;
      end else if (swr_req) begin
         busy    <= 1'b1;
         rst_cnt <= RST_W'(RST_CYCLES - 1);
      end else if (busy) begin
         if (rst_cnt == '0) busy <= 1'b0;
         else               rst_cnt <= rst_cnt - RST_W'(1);
      end
   end

   // run starts one cycle after enable so the first word is loaded first
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    en_q <= 1'b0;
      else if (clr)  en_q <= 1'b0;
      else           en_q <= ctl_en;
   end
   assign run   = ctl_en && en_q;
   assign start = ctl_en && !en_q;

   always_comb begin
      unique case (ctl_src)
         CS_BUS:  src_tick = src_bus_tick;
         CS_FAST: src_tick = src_fast_tick;
         CS_SLOW: src_tick = src_slow_tick;
         default: src_tick = 1'b0;
      endcase
   end

   pwm_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (!run),
      .src_tick (src_tick),
      .ratio_m1 (ctl_pre),
      .cnt_tick (cnt_tick)
   );

   pwm_period_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .tick     (cnt_tick),
      .last     (prd_last),
      .duty     (cur_duty),
      .cnt      (cnt),
      .rollover (rollover),
      .cmp_hit  (cmp_hit),
      .raw      (raw)
   );

   // sample consumption with repeat count
   assign rep_len_m1 = 3'((4'd1 << ctl_rpt) - 4'd1);
   assign rep_done   = rollover && (rep_cnt == rep_len_m1);
   assign pop        = !fifo_empty && (start || rep_done);

   pwm_sample_fifo #(.W(CNT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .push  (wr_smp),
      .wdata (reg_wdata[CNT_W-1:0]),
      .pop   (pop),
      .rdata (fifo_rdata),
      .level (fifo_level),
      .full  (fifo_full),
      .empty (fifo_empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rep_cnt  <= '0;
         cur_duty <= '0;
      end else if (clr) begin
         rep_cnt  <= '0;
         cur_duty <= '0;
      end else begin
         if (!run)          rep_cnt <= '0;
         else if (rollover) rep_cnt <= rep_done ? '0 : rep_cnt + 3'd1;
         if (pop)           cur_duty <= fifo_rdata;
      end
   end

   // sticky flags, set wins over a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || clr) begin
         flg_roll <= 1'b0;
         flg_cmp  <= 1'b0;
         flg_ovf  <= 1'b0;
      end else begin
         flg_roll <= rollover | (flg_roll & ~(wr_stat & reg_wdata[SB_ROLL]));
         flg_cmp  <= cmp_hit  | (flg_cmp  & ~(wr_stat & reg_wdata[SB_CMP]));
         flg_ovf  <= (wr_smp & fifo_full) | (flg_ovf & ~(wr_stat & reg_wdata[SB_OVF]));
      end
   end

   // read mux
   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(OFS_CTRL))
         reg_rdata = {12'd0, ctl_mode, ctl_src, 12'(ctl_pre), busy, ctl_rpt, ctl_en};
      else if (reg_addr == ADDR_W'(OFS_STAT))
         reg_rdata = {25'd0, flg_ovf, flg_cmp, flg_roll, fifo_empty, 3'(fifo_level)};
      else if (reg_addr == ADDR_W'(OFS_SMP))
         reg_rdata = ctl_en ? 32'(cur_duty) : 32'd0;
      else if (reg_addr == ADDR_W'(OFS_PRD))
         reg_rdata = 32'(prd_q);
   end

   // output stage
   always_comb begin
      unique case (ctl_mode)
         OM_NORM: shaped = ctl_en & raw;
         OM_INV:  shaped = ctl_en & ~raw;
         default: shaped = 1'b0;
      endcase
   end

   if (OUT_REG) begin : g_out_ff
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pwm_out <= 1'b0;
         else        pwm_out <= shaped;
      end
   end else begin : g_out_comb
      assign pwm_out = shaped;
   end

endmodule

// File: rtl/pwm_fifo_gen_chk.sv
module pwm_fifo_gen_chk #(
   parameter int CNT_W      = 16,
   parameter int FIFO_DEPTH = 4,
   parameter int ADDR_W     = 5,
   localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctl_en,
   input logic [1:0]        ctl_mode,
   input logic [1:0]        ctl_src,
   input logic              run,
   input logic [CNT_W-1:0]  cnt,
   input logic              pwm_out,
   input logic [LVL_W-1:0]  fifo_level,
   input logic              busy,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              flg_ovf
);

   // R5
   disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_en && $past(!ctl_en)) |-> !pwm_out);

   // R4
   mode_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_mode[1] && $past(ctl_mode[1])) |-> !pwm_out);

   // R8
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_level <= LVL_W'(FIFO_DEPTH));

   // R7
   no_src_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run) && ($past(ctl_src) == 2'd0)) |-> $stable(cnt));

   // R9
   full_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && !busy && (reg_addr == ADDR_W'('h0C)) && (fifo_level == LVL_W'(FIFO_DEPTH)))
      |=> flg_ovf);

   // R12
   swreset_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ((fifo_level == '0) && !ctl_en));

endmodule

bind pwm_fifo_gen pwm_fifo_gen_chk #(
   .CNT_W      (CNT_W),
   .FIFO_DEPTH (FIFO_DEPTH),
   .ADDR_W     (ADDR_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctl_en     (ctl_en),
   .ctl_mode   (ctl_mode),
   .ctl_src    (ctl_src),
   .run        (run),
   .cnt        (cnt),
   .pwm_out    (pwm_out),
   .fifo_level (fifo_level),
   .busy       (busy),
   .reg_we     (reg_we),
   .reg_addr   (reg_addr),
   .flg_ovf    (flg_ovf)
);

// File: tb/pwm_fifo_gen_tb_top.sv
`timescale 1ns/1ps
module pwm_fifo_gen_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        src_bus_tick = 1'b1;
   logic        src_fast_tick = 1'b0;
   logic        src_slow_tick = 1'b0;
   logic        pwm_out;

   int n_chk = 0;
   int n_fail = 0;

   pwm_fifo_gen dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .reg_addr      (reg_addr),
      .reg_we        (reg_we),
      .reg_wdata     (reg_wdata),
      .reg_rdata     (reg_rdata),
      .src_bus_tick  (src_bus_tick),
      .src_fast_tick (src_fast_tick),
      .src_slow_tick (src_slow_tick),
      .pwm_out       (pwm_out)
   );

   initial forever #2.5 clk = ~clk;

   // fast strobe every 2nd cycle, slow strobe every 5th cycle
   initial begin
      int ph = 0;
      forever begin
         @(negedge clk);
         src_fast_tick = ~src_fast_tick;
         ph = (ph == 4) ? 0 : ph + 1;
         src_slow_tick = (ph == 0);
      end
   end

   task automatic chk(string req, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   task automatic wr(int addr, int data);
      @(negedge clk);
      reg_addr  = 5'(addr);
      reg_wdata = 32'(data);
      reg_we    = 1'b1;
      @(negedge clk);
      reg_we    = 1'b0;
   endtask

   task automatic rd(int addr, output int data);
      @(negedge clk);
      reg_addr = 5'(addr);
      #1 data = int'(reg_rdata);
   endtask

   function automatic int mk_ctrl(int en, int rpt, int pre, int src, int mode);
      return (mode << 18) | (src << 16) | (pre << 4) | (rpt << 1) | en;
   endfunction

   task automatic sreset();
      wr('h00, 8);
      repeat (8) @(negedge clk);
   endtask

   task automatic wait_rise();
      bit p;
      p = pwm_out;
      forever begin
         @(negedge clk);
         if (!p && pwm_out) break;
         p = pwm_out;
      end
   endtask

   // call right after a detected rising edge
   task automatic meas(output int hi, output int per);
      int lo;
      hi = 1;
      forever begin
         @(negedge clk);
         if (pwm_out) hi++; else break;
      end
      lo = 1;
      forever begin
         @(negedge clk);
         if (!pwm_out) lo++; else break;
      end
      per = hi + lo;
   endtask

   task automatic t_reset();
      int v;
      rd('h00, v); chk("R1 ctrl", v, 0);
      rd('h04, v); chk("R1 status", v, 'h08);
      chk("R1 output", pwm_out, 0);
   endtask

   task automatic t_basic();
      int v, hi, per, highs;
      sreset();
      wr('h10, 8);
      wr('h0C, 3);
      wr('h00, mk_ctrl(1, 0, 0, 1, 0));
      rd('h0C, v); chk("R5 sample read enabled", v, 3);
      wait_rise();
      meas(hi, per);
      chk("R3 high ticks", hi, 3);
      chk("R2 period = prd+2", per, 10);
      rd('h04, v); chk("R11 roll+cmp flags set", v, 'h38);
      wr('h00, mk_ctrl(0, 0, 0, 1, 0));
      highs = 0;
      repeat (25) begin @(negedge clk); highs += pwm_out; end
      chk("R5 disabled output low", highs, 0);
      rd('h0C, v); chk("R5 sample read disabled", v, 0);
      wr('h04, 'h30);
      rd('h04, v); chk("R11 write-1 clears", v, 'h08);
   endtask

   task automatic t_modes();
      int hi, per, highs;
      sreset();
      wr('h10, 8);
      wr('h0C, 3);
      wr('h00, mk_ctrl(1, 0, 0, 1, 1));
      repeat (20) @(negedge clk);
      wait_rise();
      meas(hi, per);
      chk("R4 inverted high ticks", hi, 7);
      chk("R4 inverted period", per, 10);
      wr('h00, mk_ctrl(1, 0, 0, 1, 2));
      highs = 0;
      repeat (30) begin @(negedge clk); highs += pwm_out; end
      chk("R4 off mode low", highs, 0);
      wr('h00, mk_ctrl(0, 0, 0, 1, 1));
      highs = 0;
      repeat (30) begin @(negedge clk); highs += pwm_out; end
      chk("R5 disabled inverted low", highs, 0);
   endtask

   task automatic t_prescale();
      int hi, per;
      sreset();
      wr('h10, 8);
      wr('h0C, 3);
      wr('h00, mk_ctrl(1, 0, 2, 1, 0));
      wait_rise();
      meas(hi, per);
      chk("R6 divide-by-3 high", hi, 9);
      chk("R6 divide-by-3 period", per, 30);
   endtask

   task automatic t_sources();
      int hi, per, highs, v;
      sreset();
      wr('h10, 8); wr('h0C, 3);
      wr('h00, mk_ctrl(1, 0, 0, 2, 0));
      repeat (4) @(negedge clk);
      wait_rise(); meas(hi, per);
      chk("R7 fast strobe high", hi, 6);
      chk("R7 fast strobe period", per, 20);
      sreset();
      wr('h10, 8); wr('h0C, 3);
      wr('h00, mk_ctrl(1, 0, 0, 3, 0));
      repeat (12) @(negedge clk);
      wait_rise(); meas(hi, per);
      chk("R7 slow strobe high", hi, 15);
      chk("R7 slow strobe period", per, 50);
      sreset();
      wr('h10, 8); wr('h0C, 3);
      wr('h00, mk_ctrl(1, 0, 0, 0, 0));
      repeat (10) @(negedge clk);
      highs = 0;
      repeat (40) begin @(negedge clk); highs += pwm_out; end
      chk("R7 no source holds counter", highs, 40);
      rd('h04, v); chk("R7 no source no rollover", v & 'h10, 0);
   endtask

   task automatic t_fifo();
      int v, hi, per;
      sreset();
      wr('h0C, 1); wr('h0C, 2); wr('h0C, 3);
      rd('h04, v); chk("R8 level 3", v, 3);
      wr('h0C, 4);
      rd('h04, v); chk("R8 level 4 full", v, 4);
      wr('h0C, 9);
      rd('h04, v); chk("R9 drop flag", v, 'h44);
      wr('h04, 'h40);
      rd('h04, v); chk("R9 drop flag cleared", v, 4);
      wr('h10, 8);
      wr('h00, mk_ctrl(1, 0, 0, 1, 0));
      wait_rise();
      for (int i = 0; i < 5; i++) begin
         meas(hi, per);
         chk("R10 1x sequence / R9 dropped word", hi, (i < 4) ? i + 1 : 4);
      end
      rd('h04, v); chk("R8 drained empty", v & 'hF, 8);
   endtask

   task automatic t_repeat();
      int hi, per;
      sreset();
      wr('h0C, 2); wr('h0C, 4); wr('h0C, 6);
      wr('h10, 8);
      wr('h00, mk_ctrl(1, 1, 0, 1, 0));
      wait_rise();
      for (int i = 0; i < 8; i++) begin
         meas(hi, per);
         chk("R10 2x repeat", hi, (i < 4) ? 2 + 2 * (i / 2) : 6);
      end
      sreset();
      wr('h0C, 2); wr('h0C, 5);
      wr('h10, 8);
      wr('h00, mk_ctrl(1, 3, 0, 1, 0));
      wait_rise();
      for (int i = 0; i < 9; i++) begin
         meas(hi, per);
         chk("R10 8x repeat", hi, (i < 8) ? 2 : 5);
      end
   endtask

   task automatic t_swreset();
      int v;
      sreset();
      wr('h10, 8); wr('h0C, 3); wr('h0C, 4);
      wr('h00, mk_ctrl(1, 0, 0, 1, 1));
      wr('h00, 8);
      rd('h00, v); chk("R12 busy bit reads 1", v, 8);
      wr('h10, 5);
      repeat (8) @(negedge clk);
      rd('h00, v); chk("R12 self-clears", v, 0);
      rd('h04, v); chk("R12 queue flushed", v, 8);
      rd('h10, v); chk("R12 period cleared, busy write ignored", v, 0);
      chk("R12 output low", pwm_out, 0);
   endtask

   task automatic t_maxprd();
      int hi, per;
      sreset();
      wr('h10, 'hFFFF);
      wr('h0C, 1);
      wr('h00, mk_ctrl(1, 0, 0, 1, 0));
      wait_rise();
      meas(hi, per);
      chk("R2 0xFFFF high", hi, 1);
      chk("R2 0xFFFF period as 0xFFFE", per, 65536);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_modes();
      t_prescale();
      t_sources();
      t_fifo();
      t_repeat();
      t_swreset();
      t_maxprd();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule